// File: doc/BRIEF.md
# Page Translation Buffer with Permission Checking

This block is a small direct-mapped translation buffer that holds recently used page mappings. Each request carries a virtual address, an access kind (read, write or instruction fetch) and a privilege flag. The upper part of the address is the virtual page number. It selects one slot by the remainder of that number divided by the slot count, and it is compared with the tag stored in that slot. On a match the block replaces the page number with the stored frame number and keeps the in-page offset as it is. It also checks the access against the permission flags of the page. The result is registered and appears one clock after the request.

A page-table walker outside the block handles misses. It loads a slot through the fill port with the page number, the frame number and a flag byte. The requester then issues the access again. A successful access marks the cached copy as accessed, and as modified if it was a write. The response reports the accessed and modified flags as they stood before the access, so the walker can tell when the page table in memory needs an update. The response also carries the cache-disable and write-through flags of the page. A flush input empties every slot in a single cycle.

Top module: `vpage_xlate_tlb`

## Requirements
- R1: A request with `req_vld` high gives `rsp_vld` high exactly one clock later. On a clean hit, `rsp_pa` is the stored frame number followed by the request's low PAGE_BITS offset bits, which pass through unchanged.
- R2: The slot index is the virtual page number modulo ENTRIES, and the tag is the full page number. A fill writes frame, tag and the flag byte into the indexed slot and replaces whatever the slot held. The flag byte is bit0 present, bit1 writable, bit2 user-accessible, bit3 no-execute, bit4 cache-disable, bit5 write-through, bit6 accessed, bit7 modified.
- R3: A request whose slot is empty or holds another tag gives miss=1, hit=0, fault code 0, `rsp_pa`=0 and all reported flags 0.
- R4: A hit on an entry whose present bit is 0 gives fault code 1.
- R5: A user-mode access (`req_user`=1) to an entry whose user-accessible bit is 0 gives fault code 2.
- R6: A write to an entry whose writable bit is 0 gives fault code 3, in both privilege modes.
- R7: Access kind codes are 0 read, 1 write, 2 fetch and 3 read. A fetch from an entry whose no-execute bit is set gives fault code 4. Code 3 behaves exactly as a read.
- R8: When several checks fail, the code reported is the first that applies in the order 1, 2, 3, 4. A faulting hit still reports hit=1, with `rsp_pa`=0.
- R9: A clean hit sets the entry's accessed bit, and a clean write also sets its modified bit. The response reports both bits as held before the access. A faulting access changes neither bit.
- R10: On a clean hit, `rsp_cache_dis` and `rsp_wr_thru` carry the entry's cache-disable and write-through bits. On a miss or a fault they are 0.
- R11: A flush empties all slots at the next clock edge and takes priority over a fill in the same cycle, which is then dropped.
- R12: While reset is applied, and after it, no response is valid and every slot is empty.
- R13: A request in the same cycle as a fill to its slot is answered from the slot's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Empty every slot |
| fill_en | input | 1 | Load one slot from the walker |
| fill_vpn | input | VA_W-PAGE_BITS | Page number of the loaded mapping |
| fill_pfn | input | PA_W-PAGE_BITS | Frame number of the loaded mapping |
| fill_flags | input | 8 | Flag byte, layout in R2 |
| req_vld | input | 1 | Translation request |
| req_va | input | VA_W | Virtual address |
| req_kind | input | 2 | Access kind, codes in R7 |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_vld | output | 1 | Response valid |
| rsp_hit | output | 1 | Tag matched on an occupied slot |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 3 | Fault code, 0 = none |
| rsp_pa | output | PA_W | Physical address on a clean hit, else 0 |
| rsp_cache_dis | output | 1 | Page cache-disable flag |
| rsp_wr_thru | output | 1 | Page write-through flag |
| rsp_acc_prev | output | 1 | Accessed bit before this access |
| rsp_dirty_prev | output | 1 | Modified bit before this access |

## Verification
The bench targets the corner cases where a plausible design goes quietly wrong. Two pages share slot 5 (page numbers 5 and 45). A design that keeps only part of the page number as its tag would hit on the wrong page. A design that wraps the index wrongly fails at the top slot, 39. Entries that fail several checks at once expose a wrong fault priority, and a write to a read-only supervisor page exposes a check that looks only at user mode. A fault that is followed by a clean access exposes a design that updates the accessed or modified bit before it checks the access. A fill that arrives with a flush, or in the same cycle as a request to its slot, shows whether the design gets the order of operations within the cycle right.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic [1:0] {
    ACC_READ     = 2'd0,
    ACC_WRITE    = 2'd1,
    ACC_FETCH    = 2'd2,
    ACC_READ_ALT = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_PRIV   = 3'd2,
    FLT_RDONLY = 3'd3,
    FLT_NOEXEC = 3'd4
  } fault_e;

  // first member is the MSB: dirty is bit 7, present is bit 0
  typedef struct packed {
    logic dirty;
    logic accessed;
    logic wr_thru;
    logic cache_dis;
    logic no_exec;
    logic user_ok;
    logic writable;
    logic present;
  } pte_flags_t;

endpackage

// File: rtl/xlt_rst_sync.sv
module xlt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sh_q <= '0;
    else          sh_q <= sh_d;
  end

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/xlt_entry_store.sv
module xlt_entry_store
  import xlt_pkg::*;
#(
  parameter int ENTRIES = 40,
  parameter int TAG_W   = 20,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PFN_W-1:0] fill_pfn,
  input  pte_flags_t       fill_flags,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_dirty,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_used,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PFN_W-1:0] rd_pfn,
  output pte_flags_t       rd_flags
);
  logic [ENTRIES-1:0] used_vec;
  logic [TAG_W-1:0]   tag_arr [ENTRIES];
  logic [PFN_W-1:0]   pfn_arr [ENTRIES];
  pte_flags_t         flg_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             used_q, used_d;
    logic             ld_we, fl_we;
    logic [TAG_W-1:0] tag_q;
    logic [PFN_W-1:0] pfn_q;
    pte_flags_t       flg_q, flg_d;

    // next state: flush beats fill, fill beats flag update
    always_comb begin
      ld_we  = fill_en && !flush && (fill_idx == IDX_W'(g));
      fl_we  = ld_we || (upd_en && !flush && (upd_idx == IDX_W'(g)));
      used_d = flush ? 1'b0 : (ld_we ? 1'b1 : used_q);
      flg_d  = flg_q;
      if (ld_we) begin
        flg_d = fill_flags;
      end else begin
        flg_d.accessed = 1'b1;
        if (upd_dirty) flg_d.dirty = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) used_q <= 1'b0;
      else        used_q <= used_d;
    end

    always_ff @(posedge clk) begin
      if (ld_we) begin
        tag_q <= fill_tag;
        pfn_q <= fill_pfn;
      end
    end

    always_ff @(posedge clk) begin
      if (fl_we) flg_q <= flg_d;
    end

    assign used_vec[g] = used_q;
    assign tag_arr[g]  = tag_q;
    assign pfn_arr[g]  = pfn_q;
    assign flg_arr[g]  = flg_q;
  end

  always_comb begin
    rd_used  = 1'b0;
    rd_tag   = '0;
    rd_pfn   = '0;
    rd_flags = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_used  = used_vec[i];
        rd_tag   = tag_arr[i];
        rd_pfn   = pfn_arr[i];
        rd_flags = flg_arr[i];
      end
    end
  end
endmodule

// File: rtl/xlt_perm_check.sv
module xlt_perm_check
  import xlt_pkg::*;
(
  input  pte_flags_t flg,
  input  acc_kind_e  kind,
  input  logic       user_mode,
  output fault_e     fault
);
  always_comb begin
    if (!flg.present)                          fault = FLT_ABSENT;
    else if (user_mode && !flg.user_ok)        fault = FLT_PRIV;
    else if (kind == ACC_WRITE && !flg.writable) fault = FLT_RDONLY;
    else if (kind == ACC_FETCH && flg.no_exec) fault = FLT_NOEXEC;
    else                                       fault = FLT_NONE;
  end
endmodule

// File: rtl/xlt_resp_reg.sv
module xlt_resp_reg #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_n,
  input  logic            hit_n,
  input  logic            miss_n,
  input  logic [2:0]      fault_n,
  input  logic [PA_W-1:0] pa_n,
  input  logic [3:0]      side_n,
  output logic            vld_q,
  output logic            hit_q,
  output logic            miss_q,
  output logic [2:0]      fault_q,
  output logic [PA_W-1:0] pa_q,
  output logic [3:0]      side_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      fault_q <= '0;
      pa_q    <= '0;
      side_q  <= '0;
    end else begin
      vld_q   <= vld_n;
      hit_q   <= hit_n;
      miss_q  <= miss_n;
      fault_q <= fault_n;
      pa_q    <= pa_n;
      side_q  <= side_n;
    end
  end
endmodule

// File: rtl/vpage_xlate_tlb.sv
module vpage_xlate_tlb
  import xlt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      fill_en,
  input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
  input  logic [PA_W-PAGE_BITS-1:0] fill_pfn,
  input  logic [7:0]                fill_flags,
  input  logic                      req_vld,
  input  logic [VA_W-1:0]           req_va,
  input  logic [1:0]                req_kind,
  input  logic                      req_user,
  output logic                      rsp_vld,
  output logic                      rsp_hit,
  output logic                      rsp_miss,
  output logic [2:0]                rsp_fault,
  output logic [PA_W-1:0]           rsp_pa,
  output logic                      rsp_cache_dis,
  output logic                      rsp_wr_thru,
  output logic                      rsp_acc_prev,
  output logic                      rsp_dirty_prev
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             rst_n_s;
  logic [VPN_W-1:0] req_vpn;
  logic [IDX_W-1:0] req_idx, fill_idx;
  logic             rd_used;
  logic [VPN_W-1:0] rd_tag;
  logic [PFN_W-1:0] rd_pfn;
  pte_flags_t       rd_flags;
  fault_e           chk_fault;
  acc_kind_e        kind;

  logic             hit_c, miss_c, ok_c;
  logic [2:0]       fault_c;
  logic [PA_W-1:0]  pa_c;
  logic [3:0]       side_c;
  logic [3:0]       side_q;

  xlt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_n_s)
  );

  assign req_vpn  = req_va[VA_W-1:PAGE_BITS];
  assign req_idx  = IDX_W'(req_vpn % VPN_W'(ENTRIES));
  assign fill_idx = IDX_W'(fill_vpn % VPN_W'(ENTRIES));
  assign kind     = acc_kind_e'(req_kind);

  xlt_entry_store #(
    .ENTRIES(ENTRIES), .TAG_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n_s), .flush(flush),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_vpn),
    .fill_pfn(fill_pfn), .fill_flags(pte_flags_t'(fill_flags)),
    .upd_en(ok_c), .upd_idx(req_idx), .upd_dirty(kind == ACC_WRITE),
    .rd_idx(req_idx), .rd_used(rd_used), .rd_tag(rd_tag),
    .rd_pfn(rd_pfn), .rd_flags(rd_flags)
  );

  xlt_perm_check u_perm (
    .flg(rd_flags), .kind(kind), .user_mode(req_user), .fault(chk_fault)
  );

  // next-state of the response
  always_comb begin
    hit_c   = req_vld && rd_used && (rd_tag == req_vpn);
    miss_c  = req_vld && !hit_c;
    fault_c = hit_c ? chk_fault : FLT_NONE;
    ok_c    = hit_c && (fault_c == FLT_NONE);
    pa_c    = ok_c ? {rd_pfn, req_va[PAGE_BITS-1:0]} : '0;
    side_c  = ok_c ? {rd_flags.cache_dis, rd_flags.wr_thru,
                      rd_flags.accessed, rd_flags.dirty} : 4'b0;
  end

  xlt_resp_reg #(.PA_W(PA_W)) u_resp (
    .clk(clk), .rst_n(rst_n_s),
    .vld_n(req_vld), .hit_n(hit_c), .miss_n(miss_c), .fault_n(fault_c),
    .pa_n(pa_c), .side_n(side_c),
    .vld_q(rsp_vld), .hit_q(rsp_hit), .miss_q(rsp_miss), .fault_q(rsp_fault),
    .pa_q(rsp_pa), .side_q(side_q)
  );

  assign rsp_cache_dis  = side_q[3];
  assign rsp_wr_thru    = side_q[2];
  assign rsp_acc_prev   = side_q[1];
  assign rsp_dirty_prev = side_q[0];
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk #(
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 req_vld,
  input logic [1:0]           req_kind,
  input logic [PAGE_BITS-1:0] req_off,
  input logic                 rsp_vld,
  input logic                 rsp_hit,
  input logic                 rsp_miss,
  input logic [2:0]           rsp_fault,
  input logic [PA_W-1:0]      rsp_pa,
  input logic                 rsp_cache_dis,
  input logic                 rsp_wr_thru,
  input logic                 rsp_acc_prev,
  input logic                 rsp_dirty_prev
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R3
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_hit && rsp_fault == 3'd0 && rsp_pa == '0));

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (rsp_vld == $past(req_vld)));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rsp_hit && rsp_fault == 3'd0) |->
      (rsp_pa[PAGE_BITS-1:0] == $past(req_off)));

  // R6
  rdonly_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rsp_fault == 3'd3) |-> ($past(req_kind) == 2'd1));

  // R7
  noexec_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rsp_fault == 3'd4) |-> ($past(req_kind) == 2'd2));

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(flush) && req_vld) |=> rsp_miss);

  // R10
  side_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss || rsp_fault != 3'd0) |->
      !(rsp_cache_dis || rsp_wr_thru || rsp_acc_prev || rsp_dirty_prev));
endmodule

bind vpage_xlate_tlb xlt_chk #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .flush(flush), .req_vld(req_vld),
  .req_kind(req_kind), .req_off(req_va[PAGE_BITS-1:0]),
  .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_cache_dis(rsp_cache_dis),
  .rsp_wr_thru(rsp_wr_thru), .rsp_acc_prev(rsp_acc_prev),
  .rsp_dirty_prev(rsp_dirty_prev)
);

// File: tb/vpage_xlate_tlb_test.sv
module vpage_xlate_tlb_test;
  // half period 2 time units: 4 ns period, 250 MHz
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [7:0]  fill_flags = '0;
  logic        req_vld = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic        rsp_vld, rsp_hit, rsp_miss;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_pa;
  logic        rsp_cache_dis, rsp_wr_thru, rsp_acc_prev, rsp_dirty_prev;

  int tests = 0;
  int fails = 0;

  always #HALF clk = ~clk;

  vpage_xlate_tlb uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_flags(fill_flags),
    .req_vld(req_vld), .req_va(req_va), .req_kind(req_kind),
    .req_user(req_user), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_cache_dis(rsp_cache_dis), .rsp_wr_thru(rsp_wr_thru),
    .rsp_acc_prev(rsp_acc_prev), .rsp_dirty_prev(rsp_dirty_prev)
  );

  typedef struct packed {
    logic        fill;
    logic [31:0] va;
    logic [19:0] pfn;
    logic [7:0]  flg;
    logic [1:0]  kind;
    logic        usr;
    logic [3:0]  req;
    logic        ehit;
    logic [2:0]  eflt;
    logic [31:0] epa;
    logic [3:0]  eside;   // {cache_dis, wr_thru, acc_prev, dirty_prev}
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0000_5123, 20'h0,     8'h00, 2'd0, 1'b0, 4'd3,  1'b0, 3'd0, 32'h0,         4'h0}, // R3 empty
    '{1'b1, 32'h0000_5000, 20'hABCDE, 8'h07, 2'd0, 1'b0, 4'd2,  1'b0, 3'd0, 32'h0,         4'h0}, // R2 fill
    '{1'b0, 32'h0000_5123, 20'h0,     8'h00, 2'd0, 1'b1, 4'd1,  1'b1, 3'd0, 32'hABCDE123,  4'b0000}, // R1
    '{1'b0, 32'h0000_5FFF, 20'h0,     8'h00, 2'd1, 1'b1, 4'd9,  1'b1, 3'd0, 32'hABCDEFFF,  4'b0010}, // R9
    '{1'b0, 32'h0000_5000, 20'h0,     8'h00, 2'd0, 1'b0, 4'd9,  1'b1, 3'd0, 32'hABCDE000,  4'b0011}, // R9
    '{1'b0, 32'h0002_D123, 20'h0,     8'h00, 2'd0, 1'b0, 4'd2,  1'b0, 3'd0, 32'h0,         4'h0}, // R2 alias
    '{1'b1, 32'h0002_D000, 20'h12345, 8'h3D, 2'd0, 1'b0, 4'd2,  1'b0, 3'd0, 32'h0,         4'h0}, // R2 fill
    '{1'b0, 32'h0002_D456, 20'h0,     8'h00, 2'd0, 1'b1, 4'd10, 1'b1, 3'd0, 32'h12345456,  4'b1100}, // R10
    '{1'b0, 32'h0002_D456, 20'h0,     8'h00, 2'd1, 1'b1, 4'd6,  1'b1, 3'd3, 32'h0,         4'h0}, // R6
    '{1'b0, 32'h0002_D456, 20'h0,     8'h00, 2'd2, 1'b1, 4'd7,  1'b1, 3'd4, 32'h0,         4'h0}, // R7
    '{1'b0, 32'h0002_D456, 20'h0,     8'h00, 2'd0, 1'b1, 4'd9,  1'b1, 3'd0, 32'h12345456,  4'b1110}, // R9 no dirty
    '{1'b0, 32'h0000_5123, 20'h0,     8'h00, 2'd0, 1'b0, 4'd2,  1'b0, 3'd0, 32'h0,         4'h0}, // R2 evicted
    '{1'b1, 32'h0000_7000, 20'h00777, 8'h03, 2'd0, 1'b0, 4'd2,  1'b0, 3'd0, 32'h0,         4'h0},
    '{1'b0, 32'h0000_7010, 20'h0,     8'h00, 2'd0, 1'b1, 4'd5,  1'b1, 3'd2, 32'h0,         4'h0}, // R5
    '{1'b0, 32'h0000_7010, 20'h0,     8'h00, 2'd1, 1'b1, 4'd5,  1'b1, 3'd2, 32'h0,         4'h0}, // R5
    '{1'b0, 32'h0000_7010, 20'h0,     8'h00, 2'd2, 1'b0, 4'd9,  1'b1, 3'd0, 32'h00777010,  4'b0000}, // R9
    '{1'b0, 32'h0000_7010, 20'h0,     8'h00, 2'd0, 1'b0, 4'd9,  1'b1, 3'd0, 32'h00777010,  4'b0010}, // R9
    '{1'b1, 32'h0000_9000, 20'h99999, 8'h0C, 2'd0, 1'b0, 4'd2,  1'b0, 3'd0, 32'h0,         4'h0},
    '{1'b0, 32'h0000_9000, 20'h0,     8'h00, 2'd1, 1'b1, 4'd4,  1'b1, 3'd1, 32'h0,         4'h0}, // R4 R8
    '{1'b1, 32'h0000_8000, 20'h88888, 8'h09, 2'd0, 1'b0, 4'd2,  1'b0, 3'd0, 32'h0,         4'h0},
    '{1'b0, 32'h0000_8000, 20'h0,     8'h00, 2'd2, 1'b1, 4'd8,  1'b1, 3'd2, 32'h0,         4'h0}, // R8
    '{1'b0, 32'h0000_8000, 20'h0,     8'h00, 2'd2, 1'b0, 4'd7,  1'b1, 3'd4, 32'h0,         4'h0}, // R7
    '{1'b0, 32'h0000_8000, 20'h0,     8'h00, 2'd1, 1'b0, 4'd6,  1'b1, 3'd3, 32'h0,         4'h0}, // R6
    '{1'b0, 32'h0000_8ABC, 20'h0,     8'h00, 2'd3, 1'b0, 4'd7,  1'b1, 3'd0, 32'h88888ABC,  4'b0000}, // R7 code 3
    '{1'b1, 32'h0002_7000, 20'h00039, 8'h07, 2'd0, 1'b0, 4'd2,  1'b0, 3'd0, 32'h0,         4'h0},
    '{1'b0, 32'h0002_7ABC, 20'h0,     8'h00, 2'd0, 1'b1, 4'd2,  1'b1, 3'd0, 32'h00039ABC,  4'b0000}, // R2 top slot
    '{1'b0, 32'h0004_F000, 20'h0,     8'h00, 2'd0, 1'b0, 4'd2,  1'b0, 3'd0, 32'h0,         4'h0}, // R2 alias 79
    '{1'b0, 32'h0002_7ABC, 20'h0,     8'h00, 2'd0, 1'b1, 4'd2,  1'b1, 3'd0, 32'h00039ABC,  4'b0010}  // R2
  };

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", what, got, exp);
    end
  endtask

  function automatic logic [63:0] snap();
    return {22'd0, rsp_vld, rsp_hit, rsp_miss, rsp_fault, rsp_pa,
            rsp_cache_dis, rsp_wr_thru, rsp_acc_prev, rsp_dirty_prev};
  endfunction

  function automatic logic [63:0] expect_of(input logic hit, input logic [2:0] f,
                                            input logic [31:0] pa, input logic [3:0] s);
    return {22'd0, 1'b1, hit, ~hit, f, pa, s};
  endfunction

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [7:0] f);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_flags = f;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // request is driven for one cycle; outputs are sampled at the following negedge
  task automatic do_req(input logic [31:0] va, input logic [1:0] k, input logic u);
    @(negedge clk);
    req_vld = 1'b1; req_va = va; req_kind = k; req_user = u;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  initial begin : watchdog
    #(2 * HALF * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12: quiet while reset is applied
    chk("R12 in reset", {61'd0, rsp_vld, rsp_hit, rsp_miss}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 after reset", {61'd0, rsp_vld, rsp_hit, rsp_miss}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].fill) begin
        do_fill(VEC[i].va[31:12], VEC[i].pfn, VEC[i].flg);
      end else begin
        do_req(VEC[i].va, VEC[i].kind, VEC[i].usr);
        chk($sformatf("R%0d vec %0d", VEC[i].req, i), snap(),
            expect_of(VEC[i].ehit, VEC[i].eflt, VEC[i].epa, VEC[i].eside));
      end
    end

    // R11: flush together with a fill; the fill is dropped
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h0000A; fill_pfn = 20'hAAAAA; fill_flags = 8'h07;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    do_req(32'h0002_7ABC, 2'd0, 1'b0);
    chk("R11 flushed slot", snap(), expect_of(1'b0, 3'd0, 32'h0, 4'h0));
    do_req(32'h0000_A000, 2'd0, 1'b0);
    chk("R11 fill dropped", snap(), expect_of(1'b0, 3'd0, 32'h0, 4'h0));

    // R13: fill and request to the same slot in one cycle
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'h0000B; fill_pfn = 20'hBBBBB; fill_flags = 8'h07;
    req_vld = 1'b1; req_va = 32'h0000_B000; req_kind = 2'd0; req_user = 1'b0;
    @(negedge clk);
    fill_en = 1'b0; req_vld = 1'b0;
    chk("R13 old contents", snap(), expect_of(1'b0, 3'd0, 32'h0, 4'h0));
    do_req(32'h0000_B000, 2'd0, 1'b0);
    chk("R13 retry hits", snap(), expect_of(1'b1, 3'd0, 32'hBBBBB000, 4'h0));

    // R1: idle cycle gives no response
    @(negedge clk);
    chk("R1 idle", {63'd0, rsp_vld}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule